// File: doc/BRIEF.md
# Coded-Bit to PSK Symbol Mapper

This block takes one serial stream of coded bits and groups it into modulation symbols for offset QPSK, 8PSK or 16PSK. Each accepted bit arrives with a valid strobe. The symbol's bits come out on parallel rails, one rail per bit position, at the symbol rate. All bits come from a single logical encoder sequence. A symbol is always made of consecutive stream bits, so the bits of one symbol may come from the tail of one codeword and the head of the next. Grouping is never realigned at a codeword start.

In offset QPSK the first bit of each pair drives the I rail as soon as it is accepted. The second bit drives the Q rail when it is accepted, so Q moves one bit time (half a symbol) after I. In 8PSK and 16PSK all rails of a symbol are loaded together. A codeword-start input marks the first bit of each codeword. When a codeword start falls inside a symbol rather than on its first bit, the block raises a flag alongside that symbol. Angle generation, pulse shaping and the modulator itself are handled downstream.

Top module: `psk_rail_mapper`

## Requirements
- R1: While reset is asserted and after its release, until the first symbol event, `rails`, `sym_valid`, `lead_stb` and `sym_straddle` are all 0.
- R2: `order_sel` selects the symbol width: 2'b00 offset QPSK (2 bits), 2'b01 8PSK (3 bits), 2'b10 16PSK (4 bits), 2'b11 behaves as 16PSK. `sym_valid` pulses for one cycle, and it is visible after the clock edge that accepts the last bit of a symbol.
- R3: In offset QPSK the first bit of a pair is written to `rails[0]` on the edge that accepts it, with a one-cycle `lead_stb`. The second bit is written to `rails[1]` on its own accept edge, together with `sym_valid`, and `rails[3:2]` become 0.
- R4: In 8PSK the first, second and third bits of a symbol are written to `rails[0]`, `rails[1]` and `rails[2]` on the same edge as `sym_valid`, and `rails[3]` becomes 0.
- R5: In 16PSK the first through fourth bits of a symbol are written to `rails[0]` through `rails[3]` on the same edge as `sym_valid`.
- R6: The rails change only on a `lead_stb` or `sym_valid` edge. `lead_stb` occurs only in offset QPSK.
- R7: `sym_straddle` is high with `sym_valid` exactly when `cw_start` came with an accepted bit of that symbol other than its first. `cw_start` has no effect in a cycle where `bit_valid` is low.
- R8: A codeword start never realigns the grouping. With 8-bit codewords, offset QPSK produces no straddling symbols and 8PSK produces some.
- R9: The symbol width is taken from `order_sel` when the first bit of a symbol is accepted. Changes to `order_sel` during the rest of that symbol have no effect on it.
- R10: A cycle with `bit_valid` low changes no rail and produces no strobe. Gaps of any length between bits do not change the grouping.
- R11: `sym_valid` is never high in two consecutive cycles, and `lead_stb` and `sym_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| order_sel | input | 2 | Modulation order select (see R2) |
| bit_valid | input | 1 | A coded bit is presented this cycle |
| bit_data | input | 1 | Coded bit value |
| cw_start | input | 1 | The presented bit is the first bit of a codeword |
| rails | output | RAIL_CNT | Symbol rails; rail 0 carries the earliest bit of the symbol |
| lead_stb | output | 1 | Offset QPSK I-rail update strobe |
| sym_valid | output | 1 | A symbol has completed and its rails are loaded |
| sym_straddle | output | 1 | The completed symbol holds bits from two codewords |

## Verification
The embedded assertions take for granted that `bit_valid`, `bit_data`, `cw_start` and `order_sel` hold known values at every clock edge after reset. They also take for granted that `cw_start` is looked at only in cycles where a bit is accepted. The stimulus drives every input on the falling edge from an integer bit counter and so never leaves them undefined. It deliberately raises `cw_start` during idle cycles, both to exercise that input unused and to show it is ignored. It also changes `order_sel` part way through symbols, so the sampling rule of R9 is covered as well as phase changes made at symbol boundaries.

// File: rtl/psk_map_pkg.sv
package psk_map_pkg;

  typedef enum logic [1:0] {
    ORD_OQPSK  = 2'b00,
    ORD_8PSK   = 2'b01,
    ORD_16PSK  = 2'b10,
    ORD_16PSKX = 2'b11
  } psk_order_e;

  localparam int unsigned MAX_SYM_BITS = 4;
  localparam int unsigned SYM_CNT_W    = $clog2(MAX_SYM_BITS + 1);

  function automatic logic [SYM_CNT_W-1:0] bits_per_symbol(input logic [1:0] ord);
    logic [SYM_CNT_W-1:0] nb;
    case (ord)
      ORD_OQPSK: nb = SYM_CNT_W'(2);
      ORD_8PSK:  nb = SYM_CNT_W'(3);
      default:   nb = SYM_CNT_W'(4);
    endcase
    return nb;
  endfunction

endpackage

// File: rtl/psk_reset_sync.sv
module psk_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/psk_bit_gatherer.sv
module psk_bit_gatherer
  import psk_map_pkg::*;
#(
  parameter int unsigned RAIL_CNT = MAX_SYM_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           order_sel,
  input  logic                 bit_valid,
  input  logic                 bit_data,
  output logic                 ev_first,
  output logic                 ev_lead,
  output logic                 ev_done,
  output logic [RAIL_CNT-1:0]  ev_word,
  output logic [1:0]           ev_order
);

  localparam int unsigned CNT_W = (RAIL_CNT > 1) ? $clog2(RAIL_CNT) : 1;

  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [RAIL_CNT-1:0] hold_q, hold_d;
  logic [1:0]          ord_q, ord_d;
  logic                at_first;
  logic [1:0]          ord_eff;
  logic [SYM_CNT_W-1:0] width_eff;
  logic [RAIL_CNT-1:0] merged;
  logic                at_last;

  always_comb begin
    at_first  = (cnt_q == '0);
    ord_eff   = at_first ? order_sel : ord_q;
    width_eff = bits_per_symbol(ord_eff);
    merged    = at_first ? '0 : hold_q;
    merged[cnt_q] = bit_data;
    at_last   = bit_valid && ((SYM_CNT_W'(cnt_q) + SYM_CNT_W'(1)) == width_eff);
  end

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    ord_d  = ord_q;
    if (bit_valid) begin
      hold_d = merged;
      if (at_first) begin
        ord_d = order_sel;
      end
      if (at_last) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
      ord_q  <= ORD_OQPSK;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      ord_q  <= ord_d;
    end
  end

  assign ev_first = bit_valid && at_first;
  assign ev_lead  = bit_valid && at_first && (ord_eff == ORD_OQPSK);
  assign ev_done  = at_last;
  assign ev_word  = merged;
  assign ev_order = ord_eff;

  assert_count_below_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (SYM_CNT_W'(cnt_q) < bits_per_symbol(ord_q)));

  assert_idle_holds_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> ($stable(cnt_q) && $stable(ord_q)));

  assert_width_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !at_first) |=> $stable(ord_q));

endmodule

// File: rtl/psk_boundary_tracker.sv
module psk_boundary_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic cw_start,
  input  logic ev_first,
  input  logic ev_done,
  output logic ev_straddle
);

  logic seen_q, seen_d;

  always_comb begin
    seen_d = seen_q;
    if (bit_valid) begin
      if (ev_first || ev_done) begin
        seen_d = 1'b0;
      end else begin
        seen_d = seen_q | cw_start;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
    end
  end

  assign ev_straddle = ev_done && !ev_first && (seen_q || cw_start);

  assert_flag_cleared_at_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first |=> !seen_q);

  assert_flag_ignores_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(seen_q));

endmodule

// File: rtl/psk_rail_driver.sv
module psk_rail_driver
  import psk_map_pkg::*;
#(
  parameter int unsigned RAIL_CNT = MAX_SYM_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_lead,
  input  logic                ev_done,
  input  logic                ev_straddle,
  input  logic [RAIL_CNT-1:0] ev_word,
  input  logic [1:0]          ev_order,
  output logic [RAIL_CNT-1:0] rails,
  output logic                lead_stb,
  output logic                sym_valid,
  output logic                sym_straddle
);

  logic [RAIL_CNT-1:0]  rails_q, rails_d;
  logic                 lead_q, sym_q, strad_q;
  logic [SYM_CNT_W-1:0] width_ev;
  logic                 staggered;

  always_comb begin
    width_ev  = bits_per_symbol(ev_order);
    staggered = (ev_order == ORD_OQPSK);
    rails_d   = rails_q;
    if (ev_lead) begin
      rails_d[0] = ev_word[0];
    end
    if (ev_done) begin
      for (int i = 0; i < RAIL_CNT; i++) begin
        if (SYM_CNT_W'(i) >= width_ev) begin
          rails_d[i] = 1'b0;
        end else if (!(staggered && (i == 0))) begin
          rails_d[i] = ev_word[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rails_q <= '0;
      lead_q  <= 1'b0;
      sym_q   <= 1'b0;
      strad_q <= 1'b0;
    end else begin
      rails_q <= rails_d;
      lead_q  <= ev_lead;
      sym_q   <= ev_done;
      strad_q <= ev_straddle;
    end
  end

  assign rails        = rails_q;
  assign lead_stb     = lead_q;
  assign sym_valid    = sym_q;
  assign sym_straddle = strad_q;

  assert_rails_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_lead && !ev_done) |=> $stable(rails_q));

  assert_sym_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sym_q |=> !sym_q);

  assert_lead_sym_apart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_q && sym_q));

  assert_straddle_with_sym_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strad_q |-> sym_q);

endmodule

// File: rtl/psk_rail_mapper.sv
module psk_rail_mapper
  import psk_map_pkg::*;
#(
  parameter int unsigned RAIL_CNT = MAX_SYM_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          order_sel,
  input  logic                bit_valid,
  input  logic                bit_data,
  input  logic                cw_start,
  output logic [RAIL_CNT-1:0] rails,
  output logic                lead_stb,
  output logic                sym_valid,
  output logic                sym_straddle
);

  logic                rst_sync_n;
  logic                ev_first;
  logic                ev_lead;
  logic                ev_done;
  logic                ev_straddle;
  logic [RAIL_CNT-1:0] ev_word;
  logic [1:0]          ev_order;

  psk_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  psk_bit_gatherer #(.RAIL_CNT(RAIL_CNT)) u_gather (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .order_sel (order_sel),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .ev_first  (ev_first),
    .ev_lead   (ev_lead),
    .ev_done   (ev_done),
    .ev_word   (ev_word),
    .ev_order  (ev_order)
  );

  psk_boundary_tracker u_bound (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bit_valid   (bit_valid),
    .cw_start    (cw_start),
    .ev_first    (ev_first),
    .ev_done     (ev_done),
    .ev_straddle (ev_straddle)
  );

  psk_rail_driver #(.RAIL_CNT(RAIL_CNT)) u_drive (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ev_lead      (ev_lead),
    .ev_done      (ev_done),
    .ev_straddle  (ev_straddle),
    .ev_word      (ev_word),
    .ev_order     (ev_order),
    .rails        (rails),
    .lead_stb     (lead_stb),
    .sym_valid    (sym_valid),
    .sym_straddle (sym_straddle)
  );

  assert_lead_only_oqpsk_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_lead |-> (ev_order == ORD_OQPSK));

endmodule

// File: tb/test_psk_rail_mapper.sv
`timescale 1ns/1ps
module test_psk_rail_mapper;

  logic       clk;
  logic       rst_n;
  logic [1:0] order_sel;
  logic       bit_valid;
  logic       bit_data;
  logic       cw_start;
  logic [3:0] rails;
  logic       lead_stb;
  logic       sym_valid;
  logic       sym_straddle;

  psk_rail_mapper i_psk_rail_mapper (
    .clk          (clk),
    .rst_n        (rst_n),
    .order_sel    (order_sel),
    .bit_valid    (bit_valid),
    .bit_data     (bit_data),
    .cw_start     (cw_start),
    .rails        (rails),
    .lead_stb     (lead_stb),
    .sym_valid    (sym_valid),
    .sym_straddle (sym_straddle)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_vec;
  int n_bad;
  int bit_idx;
  int cw_pos;
  int strad_seen;
  bit prev_sym;

  logic [3:0] exp_rails;
  logic       exp_lead;
  logic       exp_sym;
  logic       exp_strad;
  bit         q_bit[$];
  bit         q_cws[$];
  logic [1:0] cur_ord;

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, rails, exp_rails);
    check("R2 sym_valid", {3'b0, sym_valid}, {3'b0, exp_sym});
    check("R6 lead_stb", {3'b0, lead_stb}, {3'b0, exp_lead});
    check("R7 sym_straddle", {3'b0, sym_straddle}, {3'b0, exp_strad});
    check("R11 sym spacing", {3'b0, prev_sym && sym_valid}, 4'h0);
    prev_sym = sym_valid;
    if (sym_straddle) strad_seen++;
  endtask

  // reference: symbol bits are consecutive accepted stream bits
  task automatic step(input string tag, input logic v, input logic [1:0] ord,
                      input int cw_len, input logic idle_cws);
    logic b;
    logic c;
    int   nb;
    b = 1'b0;
    c = idle_cws;
    if (v) begin
      b = ^(bit_idx[7:0] & 8'hA5);
      c = (cw_pos == 0);
      bit_idx++;
      cw_pos++;
      if (cw_pos >= cw_len) cw_pos = 0;
    end
    bit_valid = v;
    bit_data  = b;
    cw_start  = c;
    order_sel = ord;
    exp_lead  = 1'b0;
    exp_sym   = 1'b0;
    exp_strad = 1'b0;
    if (v) begin
      if (q_bit.size() == 0) cur_ord = ord;
      q_bit.push_back(b);
      q_cws.push_back(c);
      nb = (cur_ord == 2'b00) ? 2 : (cur_ord == 2'b01) ? 3 : 4;
      if (cur_ord == 2'b00 && q_bit.size() == 1) begin
        exp_rails[0] = b;
        exp_lead = 1'b1;
      end
      if (q_bit.size() == nb) begin
        for (int i = 0; i < 4; i++) begin
          if (i >= nb) exp_rails[i] = 1'b0;
          else if (!(cur_ord == 2'b00 && i == 0)) exp_rails[i] = q_bit[i];
        end
        for (int i = 1; i < nb; i++) if (q_cws[i]) exp_strad = 1'b1;
        exp_sym = 1'b1;
        q_bit.delete();
        q_cws.delete();
      end
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0; bit_idx = 0; cw_pos = 0; strad_seen = 0; prev_sym = 0;
    exp_rails = 4'h0; exp_lead = 0; exp_sym = 0; exp_strad = 0; cur_ord = 2'b00;
    rst_n = 1'b0; order_sel = 2'b00; bit_valid = 0; bit_data = 0; cw_start = 0;
    repeat (3) @(negedge clk);
    compare_all("R1 reset rails");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare_all("R1 after release");

    // R3: offset QPSK, 8-bit codewords, continuous
    strad_seen = 0;
    for (int s = 0; s < 40; s++) step("R3 oqpsk rails", 1'b1, 2'b00, 8, 1'b0);
    check("R8 oqpsk straddle count", 4'(strad_seen), 4'h0);

    // R4: 8PSK, 8-bit codewords
    strad_seen = 0;
    for (int s = 0; s < 60; s++) step("R4 8psk rails", 1'b1, 2'b01, 8, 1'b0);
    check("R8 8psk has straddles", {3'b0, strad_seen > 0}, 4'h1);

    // R5: 16PSK, 10-bit codewords
    for (int s = 0; s < 60; s++) step("R5 16psk rails", 1'b1, 2'b10, 10, 1'b0);

    // R2: code 11 acts as 16PSK
    for (int s = 0; s < 40; s++) step("R2 code11 rails", 1'b1, 2'b11, 10, 1'b0);

    // R10: gaps, idle cycles raise cw_start (R7 ignored)
    for (int s = 0; s < 90; s++)
      step("R10 gapped rails", (s % 3) != 1, 2'b01, 7, (s % 3) == 1);
    for (int s = 0; s < 40; s++)
      step("R10 oqpsk gaps", (s % 4) < 2, 2'b00, 5, (s % 4) == 3);

    // R9: order changes every cycle, taken only at a symbol's first bit
    for (int s = 0; s < 80; s++) step("R9 order switch", 1'b1, 2'(s % 4), 9, 1'b0);
    for (int s = 0; s < 12; s++) step("R9 drain", 1'b1, 2'b00, 9, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule